// File: doc/BRIEF.md
# Compare-Match Pulse Timer

This block is an up-counting timer with two compare registers that drives one output pin. The counter advances by one on each cycle where the `cnt_en` strobe from an outside prescaler is high. On every such tick the current count is compared with compare register A and compare register B. Each match can set, clear, toggle or leave the pin alone, as chosen by its own 2-bit action field. A clear-select field can return the counter to zero on a match. Clearing on match A with "set on A, clear on B" produces a free-running PWM wave: register A sets the period and register B sets the high time, with no software involvement.

Software reaches every register through a small synchronous bus. Writes take effect at the clock edge, and reads are combinational from `bus_addr`. The status register holds three event flags: match B, match A and overflow. Software can only clear these flags, by writing 0. The pin is held by a two-state machine with states PIN_LOW and PIN_HIGH. On a match tick it takes one of four transitions: SET (to PIN_HIGH), CLEAR (to PIN_LOW), TOGGLE (to the other state) or HOLD (stay).

Top module: `pulse_timer8`

## Requirements
- R1: After reset the counter reads 0x00, compare A and compare B read 0xFF, the mode register reads 0x00, the status register reads 0x10 and `pulse_out` is 0.
- R2: Each cycle with `cnt_en` high adds one to the counter, and a cycle with `cnt_en` low leaves it unchanged. A tick at 0xFF with no clear taking effect wraps the counter to 0x00 and sets the overflow flag (status bit 5).
- R3: Mode register bits 1:0 select the counter clear. 01 clears the counter to 0x00 on a tick where it equals compare A, 10 does the same for compare B, and 00 and 11 never clear.
- R4: A tick where the counter equals compare A sets status bit 6. A tick where it equals compare B sets status bit 7.
- R5: Writing 0 to a status bit in 7:5 clears that flag, and writing 1 leaves it unchanged. If a flag is set in the same cycle as a write that would clear it, the flag ends up set.
- R6: Status bit 4 always reads 1, and writes to it are ignored.
- R7: Status bits 1:0 hold the action for match A and bits 3:2 the action for match B. The codes are 00 hold, 01 drive 0, 10 drive 1 and 11 toggle. The pin shows the result from the clock edge that ends the matching tick.
- R8: When both matches occur on one tick, the match-B action is applied unless it is 00. In that case the match-A action is applied.
- R9: With clear select 01, status action bits 0110 and compare B below compare A, the pin repeats every A+1 ticks and is high for B+1 ticks of each period.
- R10: The bus addresses are 0 for the counter, 1 for compare A, 2 for compare B, 3 for the mode register and 4 for the status register. Addresses 5 to 7 read 0. A counter write overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick from the prescaler |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` |
| pulse_out | output | 1 | Compare-match output pin |

## Verification
The assertions assume that `cnt_en` and the bus inputs are stable around each rising clock edge. They also assume that a counter write is the only thing other than a tick that can move the counter. The bench respects both assumptions by changing every input only on the falling edge. Its random phase draws ticks on about half of all cycles and bus writes on about one cycle in eight, spread over all eight addresses. This lets counter overwrites, flag clears and action changes fall on the same cycles as matches and wraps.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_RSVD = 2'b11
    } clr_sel_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned FLAG_N    = 3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    // flag vector order: [2]=match B, [1]=match A, [0]=overflow
    localparam int unsigned FLAG_LSB  = 5;
    localparam int unsigned RSVD_BIT  = 4;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  clr_sel_e     clr_sel,
    output logic [W-1:0] cnt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         clr_now;

    always_comb begin
        hit_a   = tick && (cnt_q == cmp_a);
        hit_b   = tick && (cnt_q == cmp_b);
        clr_now = ((clr_sel == CLR_ON_A) && hit_a) || ((clr_sel == CLR_ON_B) && hit_b);
        wrap    = tick && (&cnt_q) && !clr_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (clr_now)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + W'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic              wrap,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] keep_mask,
    output logic [FLAG_N-1:0] flags
);
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_vec;

    assign set_vec = {hit_b, hit_a, wrap};

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (clr_wr)
            flags_q <= (flags_q & keep_mask) | set_vec;
        else
            flags_q <= flags_q | set_vec;
    end

    assign flags = flags_q;
endmodule

// File: rtl/tmr8_pin_fsm.sv
module tmr8_pin_fsm
    import tmr8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit_a,
    input  logic     hit_b,
    input  pin_act_e act_a,
    input  pin_act_e act_b,
    output logic     pin
);
    pin_state_e state_q;
    pin_state_e state_d;
    pin_act_e   act;

    always_comb begin
        if (hit_b && (act_b != ACT_HOLD))
            act = act_b;
        else if (hit_a)
            act = act_a;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW: begin
                if (act == ACT_HIGH || act == ACT_FLIP)
                    state_d = PIN_HIGH;          // SET / TOGGLE
            end
            PIN_HIGH: begin
                if (act == ACT_LOW || act == ACT_FLIP)
                    state_d = PIN_LOW;           // CLEAR / TOGGLE
            end
            default: state_d = PIN_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PIN_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        pin = (state_q == PIN_HIGH);
    end
endmodule

// File: rtl/pulse_timer8.sv
module pulse_timer8
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              pulse_out
);
    localparam int unsigned STAT_W = 8;

    logic [W-1:0]      cmp_a_q;
    logic [W-1:0]      cmp_b_q;
    clr_sel_e          clr_sel_q;
    pin_act_e          act_a_q;
    pin_act_e          act_b_q;
    logic [W-1:0]      cnt_val;
    logic [FLAG_N-1:0] flag_vec;
    logic              hit_a;
    logic              hit_b;
    logic              wrap;
    logic              wr_cnt;
    logic              wr_stat;
    logic [STAT_W-1:0] stat_rd;

    assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a_q   <= '1;
            cmp_b_q   <= '1;
            clr_sel_q <= CLR_NONE;
            act_a_q   <= ACT_HOLD;
            act_b_q   <= ACT_HOLD;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CMPA: cmp_a_q   <= bus_wdata;
                A_CMPB: cmp_b_q   <= bus_wdata;
                A_MODE: clr_sel_q <= clr_sel_e'(bus_wdata[1:0]);
                A_STAT: begin
                    act_a_q <= pin_act_e'(bus_wdata[1:0]);
                    act_b_q <= pin_act_e'(bus_wdata[3:2]);
                end
                default: ;
            endcase
        end
    end

    tmr8_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_en),
        .ld      (wr_cnt),
        .ld_val  (bus_wdata),
        .cmp_a   (cmp_a_q),
        .cmp_b   (cmp_b_q),
        .clr_sel (clr_sel_q),
        .cnt     (cnt_val),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .wrap    (wrap)
    );

    tmr8_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .wrap      (wrap),
        .clr_wr    (wr_stat),
        .keep_mask (bus_wdata[FLAG_LSB +: FLAG_N]),
        .flags     (flag_vec)
    );

    tmr8_pin_fsm u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .act_a (act_a_q),
        .act_b (act_b_q),
        .pin   (pulse_out)
    );

    assign stat_rd = {flag_vec, 1'b1, act_b_q, act_a_q};

    always_comb begin
        unique case (bus_addr)
            A_CNT:   bus_rdata = cnt_val;
            A_CMPA:  bus_rdata = cmp_a_q;
            A_CMPB:  bus_rdata = cmp_b_q;
            A_MODE:  bus_rdata = W'(clr_sel_q);
            A_STAT:  bus_rdata = W'(stat_rd);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pulse_timer8_chk.sv
module pulse_timer8_chk
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_rdata,
    input logic              pulse_out,
    input logic [W-1:0]      cnt_val,
    input logic [W-1:0]      cmp_a_q,
    input logic [1:0]        clr_sel_q,
    input logic [FLAG_N-1:0] flag_vec
);
    logic ld_cnt;
    assign ld_cnt = bus_wr && (bus_addr == A_CNT);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !$past(ld_cnt)) |-> $stable(cnt_val)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_en) && !$past(ld_cnt)) |-> (cnt_val == $past(cnt_val) + W'(1) || cnt_val == '0)); // R2

    AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_en && !ld_cnt && clr_sel_q == 2'b01 && cnt_val == cmp_a_q) |-> (cnt_val == '0)); // R3

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_en) |-> ((flag_vec & ~$past(flag_vec)) == '0)); // R5

    AST_RSVD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> bus_rdata[RSVD_BIT]); // R6

    AST_PIN_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_en) |-> $stable(pulse_out)); // R7
endmodule

bind pulse_timer8 pulse_timer8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .pulse_out (pulse_out),
    .cnt_val   (cnt_val),
    .cmp_a_q   (cmp_a_q),
    .clr_sel_q (clr_sel_q),
    .flag_vec  (flag_vec)
);

// File: tb/test_pulse_timer8.sv
module test_pulse_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pulse_out;

    int checks = 0;
    int bad = 0;
    logic [7:0] last_rd;

    // reference state
    logic [7:0] m_cnt, m_a, m_b;
    logic [1:0] m_clr, m_osa, m_osb;
    logic [2:0] m_fl;
    logic       m_pin;

    always #4 clk = ~clk;

    pulse_timer8 i_pulse_timer8 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_out(pulse_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return m_a;
            3'd2: return m_b;
            3'd3: return {6'd0, m_clr};
            3'd4: return {m_fl, 1'b1, m_osb, m_osa};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic apply_act(input logic p, input logic [1:0] act);
        case (act)
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            2'b11: return ~p;
            default: return p;
        endcase
    endfunction

    task automatic model_step(input logic en, input logic we, input logic [2:0] a, input logic [7:0] d);
        logic ma, mb, clr_now;
        logic [1:0] act;
        ma = en && (m_cnt == m_a);
        mb = en && (m_cnt == m_b);
        clr_now = (m_clr == 2'b01 && ma) || (m_clr == 2'b10 && mb);
        act = (mb && m_osb != 2'b00) ? m_osb : (ma ? m_osa : 2'b00);
        m_pin = apply_act(m_pin, act);
        if (we && a == 3'd4) m_fl = m_fl & d[7:5];
        m_fl = m_fl | {mb, ma, en && m_cnt == 8'hFF && !clr_now};
        if (we && a == 3'd0) m_cnt = d;
        else if (clr_now) m_cnt = 8'h00;
        else if (en) m_cnt = m_cnt + 8'd1;
        if (we) begin
            case (a)
                3'd1: m_a = d;
                3'd2: m_b = d;
                3'd3: m_clr = d[1:0];
                3'd4: begin m_osa = d[1:0]; m_osb = d[3:2]; end
                default: ;
            endcase
        end
    endtask

    // drives at the falling edge, model advances at the rising edge, checked at next fall
    task automatic cycle(input logic en, input logic we, input logic [2:0] a, input logic [7:0] d);
        cnt_en = en; bus_wr = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(en, we, a, d);
        @(negedge clk);
        cnt_en = 1'b0; bus_wr = 1'b0;
        last_rd = bus_rdata;
        chk("R10 model read", bus_rdata, model_read(a));
        chk("R7 model pin", {7'd0, pulse_out}, {7'd0, m_pin});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cycle(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        cycle(1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int highs, rises;
        logic prev;
        void'($urandom(32'h1234_abcd));
        m_cnt = 8'h00; m_a = 8'hFF; m_b = 8'hFF; m_clr = 2'b00;
        m_osa = 2'b00; m_osb = 2'b00; m_fl = 3'b000; m_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 pin", {7'd0, pulse_out}, 8'h00);
        rd(3'd0); chk("R1 counter", last_rd, 8'h00);
        rd(3'd1); chk("R1 compare A", last_rd, 8'hFF);
        rd(3'd2); chk("R1 compare B", last_rd, 8'hFF);
        rd(3'd3); chk("R1 mode", last_rd, 8'h00);
        rd(3'd4); chk("R1 status", last_rd, 8'h10);
        rd(3'd6); chk("R10 unused address", last_rd, 8'h00);

        // R6 reserved bit, R5 writing ones leaves flags clear
        wr(3'd4, 8'hEF); chk("R6 status after write", last_rd, 8'h1F);
        wr(3'd4, 8'h00); chk("R6 bit4 still one", last_rd, 8'h10);

        // R2 count, wrap, overflow flag
        wr(3'd0, 8'hFE);
        ticks(1); rd(3'd0); chk("R2 count step", last_rd, 8'hFF);
        cycle(1'b0, 1'b0, 3'd0, 8'h00); chk("R2 hold without tick", last_rd, 8'hFF);
        ticks(1); rd(3'd0); chk("R2 wrap", last_rd, 8'h00);
        rd(3'd4); chk("R2 overflow flag", last_rd & 8'h20, 8'h20);

        // R5 clear by zero, set wins over clear
        wr(3'd4, 8'hE0); chk("R5 write one keeps flag", last_rd & 8'h20, 8'h20);
        wr(3'd4, 8'h00); chk("R5 write zero clears", last_rd & 8'hE0, 8'h00);
        wr(3'd0, 8'hFF);
        cycle(1'b1, 1'b1, 3'd4, 8'h00); chk("R5 set beats clear", last_rd & 8'h20, 8'h20);

        // R4 / R7 match flags and pin actions
        wr(3'd1, 8'd5); wr(3'd2, 8'd9); wr(3'd4, 8'h06); wr(3'd0, 8'd0);
        ticks(5); chk("R7 pin before match A", {7'd0, pulse_out}, 8'h00);
        ticks(1); chk("R7 drive 1 on A", {7'd0, pulse_out}, 8'h01);
        rd(3'd4); chk("R4 flag A", last_rd & 8'hC0, 8'h40);
        ticks(4); chk("R7 drive 0 on B", {7'd0, pulse_out}, 8'h00);
        rd(3'd4); chk("R4 flag B", last_rd & 8'hC0, 8'hC0);

        // R8 simultaneous matches
        wr(3'd1, 8'd3); wr(3'd2, 8'd3); wr(3'd0, 8'd3);
        ticks(1); chk("R8 B action wins", {7'd0, pulse_out}, 8'h00);
        wr(3'd4, 8'h02); wr(3'd0, 8'd3);
        ticks(1); chk("R8 A applies when B holds", {7'd0, pulse_out}, 8'h01);
        wr(3'd4, 8'h0C); wr(3'd0, 8'd3);
        ticks(1); chk("R7 toggle", {7'd0, pulse_out}, 8'h00);

        // R3 clear selection
        wr(3'd4, 8'h00); wr(3'd3, 8'h02); wr(3'd2, 8'd3); wr(3'd1, 8'd9); wr(3'd0, 8'd0);
        ticks(4); rd(3'd0); chk("R3 clear on B", last_rd, 8'h00);
        wr(3'd3, 8'h03); wr(3'd0, 8'd3);
        ticks(1); rd(3'd0); chk("R3 code 11 no clear", last_rd, 8'h04);
        wr(3'd3, 8'h01); wr(3'd0, 8'd9);
        ticks(1); rd(3'd0); chk("R3 clear on A", last_rd, 8'h00);

        // R9 PWM: A=4, B=1 -> period 5, high 2
        wr(3'd1, 8'd4); wr(3'd2, 8'd1); wr(3'd4, 8'h06); wr(3'd0, 8'd0);
        ticks(20);
        highs = 0; rises = 0; prev = pulse_out;
        for (int i = 0; i < 25; i++) begin
            ticks(1);
            if (pulse_out) highs++;
            if (pulse_out && !prev) rises++;
            prev = pulse_out;
        end
        chk("R9 high time", 8'(highs), 8'd10);
        chk("R9 period", 8'(rises), 8'd5);

        // random phase against the reference model
        for (int i = 0; i < 3000; i++) begin
            logic en, we;
            logic [2:0] a;
            logic [7:0] d;
            en = ($urandom % 2) == 0;
            we = ($urandom % 8) == 0;
            a  = 3'($urandom % 8);
            d  = 8'($urandom);
            if (we && a == 3'd1) d = d % 8'd40;
            if (we && a == 3'd2) d = d % 8'd40;
            cycle(en, we, a, d);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule